// File: doc/BRIEF.md
# SAR Capacitor Switching Sequencer

This block is the synchronous control core of a differential successive-approximation converter whose two binary-weighted capacitor arrays switch their bottom plates between ground and a low assistant reference, one quarter of the main reference. A start request opens a sampling window of programmable length. During that window the top plates track the inputs, the two heaviest bottom plates of each array follow the inputs, and every other bottom plate sits at ground. When the window closes, the sequencer loads the starting pattern and strobes the comparator once per clock until all N bits are resolved.

Each decision moves exactly one capacitor. The heaviest capacitor on one side is raised from ground, or a lighter one is dropped from the assistant reference to ground. The final decision moves nothing. The resolved word is published with a one-cycle completion pulse. Because the sampling configuration connects no bottom plate to the assistant reference, that reference supplies no charge at reset of the arrays. The comparator, switches and analog arrays lie outside the block.

Top module: `sar_swseq_ctrl`

## Requirements
- R1: While reset is asserted and until the first start, every output is 0, including both select vectors and `code_o`.
- R2: A `start_i` seen in idle raises `samp_top_o` and `samp_bot_o` from the next cycle for L cycles. L is `samp_len_i` captured with the start, and a value of 0 counts as 1. Both select vectors are all 0 (ground) throughout that window.
- R3: In the first strobe cycle, before any switching, both select vectors hold bit N-2 at 0 and every lower bit at 1 (1 = assistant reference, 0 = ground).
- R4: `strobe_o` is high for exactly N consecutive cycles right after the sampling window and never together with the sampling controls. `cmp_i` is taken at the clock edge that closes each strobe cycle.
- R5: After the first decision, bit N-2 of `sel_n_o` rises if the decision was 1, or bit N-2 of `sel_p_o` rises if it was 0. Nothing else changes.
- R6: The decision for output bit j, with N-2 >= j >= 1, drops bit j-1 of `sel_p_o` when 1 or bit j-1 of `sel_n_o` when 0. The bit-0 decision changes no select.
- R7: Between consecutive strobe cycles exactly one select bit changes, and none changes after the last strobe. Bit N-2 only ever rises during conversion, and lower bits only ever fall.
- R8: `done_o` is high for one cycle, the cycle after the last strobe. `code_o` changes only in that cycle, and its bit N-1 is the first decision, down to bit 0 as the last.
- R9: A `start_i` during sampling or conversion has no effect on the running conversion, and no new window follows it.
- R10: Read each select vector as an unsigned binary number. With an ideal comparator deciding 1 exactly when the differential input d (in LSB, -2^(N-1) <= d < 2^(N-1)) is at least value(`sel_n_o`) - value(`sel_p_o`), `code_o` equals d + 2^(N-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to sample and convert |
| samp_len_i | input | SLW | Sampling window length in cycles (0 treated as 1) |
| cmp_i | input | 1 | Comparator decision, 1 = positive side higher |
| samp_top_o | output | 1 | Top-plate input switches closed |
| samp_bot_o | output | 1 | Bottom plates of the two heaviest capacitors on the inputs |
| strobe_o | output | 1 | Comparator evaluate strobe |
| sel_p_o | output | N-1 | Positive-array bottom-plate selects, 1 = assistant reference |
| sel_n_o | output | N-1 | Negative-array bottom-plate selects, 1 = assistant reference |
| code_o | output | N | Converted code, held between conversions |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The sampling controls are due one cycle after the edge that takes `start_i` and stay up for exactly L cycles. The first strobe follows in the next cycle, the selects settle one cycle after each decision edge, and `done_o` with the new code comes one cycle after the last strobe. The bench walks this schedule with its own counters, sampling every output on the falling edge. At each strobe it compares the array imbalance with a threshold it advances from the input value alone, so a decision applied one cycle late or to the wrong capacitor shows up in the very cycle it occurs.

// File: rtl/sar_swseq_pkg.sv
package sar_swseq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SAMPLE = 2'd1,
        PH_CONV   = 2'd2
    } phase_e;

    // bottom-plate select of one capacitor weight on both arrays
    typedef struct packed {
        logic pos;
        logic neg;
    } cap_pair_t;

endpackage

// File: rtl/sar_phase_seq.sv
module sar_phase_seq
    import sar_swseq_pkg::*;
#(
    parameter int N   = 10,
    parameter int SLW = 8,
    localparam int IW = $clog2(N)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [SLW-1:0] samp_len_i,
    output phase_e         phase_o,
    output logic [IW-1:0]  bit_idx_o,
    output logic           clear_o,
    output logic           load_o,
    output logic           last_o
);

    typedef struct packed {
        phase_e         phase;
        logic [SLW-1:0] cnt;
        logic [IW-1:0]  bidx;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        clear_o = 1'b0;
        load_o  = 1'b0;
        last_o  = 1'b0;
        case (s_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    s_d.phase = PH_SAMPLE;
                    s_d.cnt   = (samp_len_i == '0) ? '0 : samp_len_i - 1'b1;
                    clear_o   = 1'b1;
                end
            end
            PH_SAMPLE: begin
                if (s_q.cnt == '0) begin
                    s_d.phase = PH_CONV;
                    s_d.bidx  = IW'(N - 1);
                    load_o    = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            PH_CONV: begin
                if (s_q.bidx == '0) begin
                    s_d.phase = PH_IDLE;
                    last_o    = 1'b1;
                end else begin
                    s_d.bidx = s_q.bidx - 1'b1;
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, cnt: '0, bidx: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign phase_o   = s_q.phase;
    assign bit_idx_o = s_q.bidx;

endmodule

// File: rtl/sar_cap_bank.sv
module sar_cap_bank
    import sar_swseq_pkg::*;
#(
    parameter int N = 10,
    localparam int NC = N - 1,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          load_i,
    input  logic          decide_i,
    input  logic [IW-1:0] bit_idx_i,
    input  logic          cmp_i,
    output logic [NC-1:0] sel_p_o,
    output logic [NC-1:0] sel_n_o
);

    for (genvar k = 0; k < NC; k++) begin : g_cap
        // the heaviest weight starts at ground and can only rise;
        // every lighter weight starts at the assistant reference and can only fall
        localparam logic IS_TOP = (k == NC - 1);
        localparam logic [IW-1:0] OWNER = IW'(k + 1);

        cap_pair_t c_d, c_q;
        logic      hit_neg;

        assign hit_neg = (cmp_i == IS_TOP);

        always_comb begin
            c_d = c_q;
            if (clear_i) begin
                c_d = '0;
            end else if (load_i) begin
                c_d.pos = !IS_TOP;
                c_d.neg = !IS_TOP;
            end else if (decide_i && bit_idx_i == OWNER) begin
                if (hit_neg) c_d.neg = IS_TOP;
                else         c_d.pos = IS_TOP;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) c_q <= '0;
            else        c_q <= c_d;
        end

        assign sel_p_o[k] = c_q.pos;
        assign sel_n_o[k] = c_q.neg;
    end

endmodule

// File: rtl/sar_code_reg.sv
module sar_code_reg #(
    parameter int N = 10,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          decide_i,
    input  logic          last_i,
    input  logic [IW-1:0] bit_idx_i,
    input  logic          cmp_i,
    output logic [N-1:0]  code_o,
    output logic          done_o
);

    typedef struct packed {
        logic [N-1:0] work;
        logic [N-1:0] code;
        logic         done;
    } acc_t;

    acc_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (clear_i) r_d.work = '0;
        if (decide_i) begin
            for (int i = 0; i < N; i++) begin
                if (bit_idx_i == IW'(i)) r_d.work[i] = cmp_i;
            end
        end
        if (last_i) begin
            r_d.code = r_d.work;
            r_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign code_o = r_q.code;
    assign done_o = r_q.done;

endmodule

// File: rtl/sar_swseq_ctrl.sv
module sar_swseq_ctrl
    import sar_swseq_pkg::*;
#(
    parameter int N   = 10,
    parameter int SLW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [SLW-1:0] samp_len_i,
    input  logic           cmp_i,
    output logic           samp_top_o,
    output logic           samp_bot_o,
    output logic           strobe_o,
    output logic [N-2:0]   sel_p_o,
    output logic [N-2:0]   sel_n_o,
    output logic [N-1:0]   code_o,
    output logic           done_o
);

    localparam int IW = $clog2(N);

    phase_e        phase;
    logic [IW-1:0] bit_idx;
    logic          clear, load, last, deciding;

    sar_phase_seq #(.N(N), .SLW(SLW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .samp_len_i (samp_len_i),
        .phase_o    (phase),
        .bit_idx_o  (bit_idx),
        .clear_o    (clear),
        .load_o     (load),
        .last_o     (last)
    );

    assign deciding = (phase == PH_CONV);

    sar_cap_bank #(.N(N)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (clear),
        .load_i    (load),
        .decide_i  (deciding),
        .bit_idx_i (bit_idx),
        .cmp_i     (cmp_i),
        .sel_p_o   (sel_p_o),
        .sel_n_o   (sel_n_o)
    );

    sar_code_reg #(.N(N)) u_code (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (clear),
        .decide_i  (deciding),
        .last_i    (last),
        .bit_idx_i (bit_idx),
        .cmp_i     (cmp_i),
        .code_o    (code_o),
        .done_o    (done_o)
    );

    assign samp_top_o = (phase == PH_SAMPLE);
    assign samp_bot_o = (phase == PH_SAMPLE);
    assign strobe_o   = deciding;

endmodule

// File: rtl/sar_swseq_chk.sv
module sar_swseq_chk #(
    parameter int N   = 10,
    parameter int SLW = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         samp_top_o,
    input logic         strobe_o,
    input logic [N-2:0] sel_p_o,
    input logic [N-2:0] sel_n_o,
    input logic [N-1:0] code_o,
    input logic         done_o
);

    localparam logic [N-2:0] TOP_M = {1'b1, {(N-2){1'b0}}};
    localparam logic [N-2:0] LOW_M = {1'b0, {(N-2){1'b1}}};

    logic seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    AST_SAMP_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        samp_top_o |-> !strobe_o); // R4

    AST_SAMP_GROUND: assert property (@(posedge clk) disable iff (!rst_n)
        samp_top_o |-> (sel_p_o == '0 && sel_n_o == '0)); // R2

    AST_ONE_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && strobe_o && $past(strobe_o)) |->
        ($countones({sel_p_o ^ $past(sel_p_o), sel_n_o ^ $past(sel_n_o)}) == 1)); // R7

    AST_SETTLED_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !strobe_o && $past(strobe_o)) |->
        (sel_p_o == $past(sel_p_o) && sel_n_o == $past(sel_n_o))); // R7

    AST_TOP_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && strobe_o && $past(strobe_o)) |->
        ((((~sel_p_o & $past(sel_p_o)) | (~sel_n_o & $past(sel_n_o))) & TOP_M) == '0)); // R7

    AST_LOW_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && strobe_o && $past(strobe_o)) |->
        ((((sel_p_o & ~$past(sel_p_o)) | (sel_n_o & ~$past(sel_n_o))) & LOW_M) == '0)); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8

    AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && done_o) |-> ($past(strobe_o) && !strobe_o)); // R8

    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !done_o) |-> $stable(code_o)); // R8

endmodule

bind sar_swseq_ctrl sar_swseq_chk #(.N(N), .SLW(SLW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .samp_top_o (samp_top_o),
    .strobe_o   (strobe_o),
    .sel_p_o    (sel_p_o),
    .sel_n_o    (sel_n_o),
    .code_o     (code_o),
    .done_o     (done_o)
);

// File: tb/tb_sar_swseq_ctrl.sv
`timescale 1ns/1ps
module tb_sar_swseq_ctrl;

    localparam int N    = 10;
    localparam int SLW  = 8;
    localparam int HALF = 1 << (N - 1);
    localparam int LOADV = (1 << (N - 2)) - 1;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           start;
    logic [SLW-1:0] samp_len;
    logic           cmp;
    logic           samp_top, samp_bot, strobe, done;
    logic [N-2:0]   sel_p, sel_n;
    logic [N-1:0]   code;

    int dv;
    int n_cmp = 0;
    int n_bad = 0;
    int prev_code = 0;

    always #2 clk = ~clk;

    sar_swseq_ctrl #(.N(N), .SLW(SLW)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .samp_len_i (samp_len),
        .cmp_i      (cmp),
        .samp_top_o (samp_top),
        .samp_bot_o (samp_bot),
        .strobe_o   (strobe),
        .sel_p_o    (sel_p),
        .sel_n_o    (sel_n),
        .code_o     (code),
        .done_o     (done)
    );

    // behavioural arrays and ideal comparator: imbalance in LSB, half-LSB input offset
    always_comb cmp = ((2 * dv + 1) > 2 * (int'(sel_n) - int'(sel_p)));

    task automatic chk(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic run_conv(int d, int len, bit poke, int len_after);
        int eff;
        int thr;
        int prev_sel;
        int cur_sel;
        int step;
        dv  = d;
        eff = (len == 0) ? 1 : len;
        @(negedge clk);
        start    = 1'b1;
        samp_len = SLW'(len);
        @(negedge clk);
        start    = 1'b0;
        samp_len = SLW'(len_after);
        for (int i = 0; i < eff; i++) begin
            chk("R2 samp_top", int'(samp_top), 1);
            chk("R2 samp_bot", int'(samp_bot), 1);
            chk("R2 sel_p ground", int'(sel_p), 0);
            chk("R2 sel_n ground", int'(sel_n), 0);
            chk("R4 no strobe while sampling", int'(strobe), 0);
            chk("R8 code held", int'(code), prev_code);
            chk("R8 done low", int'(done), 0);
            @(negedge clk);
        end
        thr      = 0;
        prev_sel = 0;
        for (int b = N - 1; b >= 0; b--) begin
            start   = poke && (b == N - 3);
            cur_sel = int'({sel_p, sel_n});
            chk("R4 strobe", int'(strobe), 1);
            chk("R4 sampling off", int'(samp_top), 0);
            chk("R8 done low", int'(done), 0);
            chk("R8 code held", int'(code), prev_code);
            if (b == N - 1) begin
                chk("R3 sel_p start", int'(sel_p), LOADV);
                chk("R3 sel_n start", int'(sel_n), LOADV);
            end else begin
                chk("R7 single switch", $countones(cur_sel ^ prev_sel), 1);
                chk(b == N - 2 ? "R5 threshold" : "R6 threshold",
                    int'(sel_n) - int'(sel_p), thr);
            end
            if (b == N - 1)  step = 1 << (N - 2);
            else if (b > 0)  step = 1 << (b - 1);
            else             step = 0;
            thr      = (d >= thr) ? thr + step : thr - step;
            prev_sel = cur_sel;
            @(negedge clk);
        end
        start = 1'b0;
        chk("R8 done pulse", int'(done), 1);
        chk("R10 code", int'(code), d + HALF);
        chk("R4 strobe ended", int'(strobe), 0);
        chk("R6 LSB no switch", int'({sel_p, sel_n}), prev_sel);
        prev_code = d + HALF;
        @(negedge clk);
        chk("R8 done one cycle", int'(done), 0);
        chk("R9 no restart", int'(samp_top), 0);
        chk("R8 code held after", int'(code), prev_code);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        rst_n    = 1'b0;
        start    = 1'b0;
        samp_len = '0;
        dv       = 0;
        repeat (3) @(negedge clk);
        chk("R1 reset samp", int'(samp_top), 0);
        chk("R1 reset strobe", int'(strobe), 0);
        chk("R1 reset sel", int'({sel_p, sel_n}), 0);
        chk("R1 reset code", int'(code), 0);
        chk("R1 reset done", int'(done), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle samp", int'(samp_bot), 0);
        chk("R1 idle sel", int'({sel_p, sel_n}), 0);
        chk("R1 idle done", int'(done), 0);

        run_conv(100, 3, 1'b0, 3);
        run_conv(-HALF, 0, 1'b0, 7);          // R2 zero length acts as one
        run_conv(HALF - 1, 1, 1'b0, 0);
        run_conv(-1, 5, 1'b1, 2);             // R9 start during conversion
        run_conv(0, 255, 1'b0, 1);
        repeat (4) @(negedge clk);
        chk("R9 idle stays idle", int'(samp_top), 0);
        for (int d = -HALF; d < HALF; d++) begin
            run_conv(d, 1 + (d & 1), d % 97 == 0, (d & 3) * 9);
        end
        summary();
        $finish;
    end

endmodule